// File: doc/BRIEF.md
# Key-Gated Register Write Protection

This block holds a bank of configuration registers behind a simple register bus. The bus has an address, write data, a write strobe and combinational read data. Some of these registers are guarded, and a guarded register accepts a bus write only while its guard is open. Reads are never blocked.

There are two kinds of guard:

- **Single-lock guard.** It belongs to one register. It opens when the right key is written to that register's lock address. It closes again by itself after a short window. Writing zero, or any wrong nonzero key, closes it at once.
- **Kick pair.** It is shared by several registers. It is open only while two kick registers hold their two keys. Software clears both kick registers after the protected write.

A register that has its own lock ignores the kick pair. Keys, register assignments and addresses are parameters. A write that is refused is dropped silently.

Top module: `key_guarded_regs`

## Requirements
- R1: After reset, every configuration register and both kick registers read zero, and every lock address reads zero (closed).
- R2: Configuration registers with no guard accept every write. Reads of any configuration register, guarded or not and locked or not, return its current contents. The defaults make registers 0 and 3 unguarded, with configuration register i at address i.
- R3: Writing the right key to a used lock address (slot j at address 16+j) opens that slot. A write to the register the slot guards is stored if it lands in any of the WINDOW cycles that follow the key-write cycle. WINDOW defaults to 4. Slot 0 guards register 1, slot 1 guards register 2 and slot 3 guards register 4.
- R4: A guarded write landing WINDOW+1 or more cycles after the key write is dropped.
- R5: Writing zero to a lock address closes that slot at once, so the next write to its register is dropped.
- R6: Writing a wrong nonzero value to a lock address leaves the slot closed and cancels an unlock still pending.
- R7: A dropped write leaves the stored value unchanged.
- R8: A kick-guarded register (defaults: 5, 6, 7) accepts writes only while the kick register at address 24 holds its key and the one at address 25 holds its own key. One correct key alone is not enough.
- R9: Writing zero to the kick registers relocks the kick-guarded registers.
- R10: A register with a used lock slot is governed only by that slot. An open kick pair does not let a write through, and a closed kick pair does not block a write in the slot's window. Register 1 is in the kick mask and also has slot 0.
- R11: A lock slot whose key is zero is unused. Its register is not lock-guarded (register 3 by default), and writes to its lock address (18) have no effect.
- R12: A lock address reads 1 in bit 0 while the slot is open. Kick addresses read back the stored value. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| cfg_out | output | N_CFG*DATA_W | All configuration register contents, register i at bits i*DATA_W |

## Verification
A write is captured on the rising edge in the cycle it is presented. Its result is visible on the read port in the next cycle, because reads are combinational. A lock slot opened on edge k accepts guarded writes on edges k+1 through k+WINDOW.

The bench drives each write half a cycle before its edge, one write per cycle. Reads are idle bus cycles, so every read between a key write and a guarded write uses up one window cycle. The window tests therefore place the guarded write at an exact idle-cycle count after the key: three idle cycles for the last accepted edge, four for the first refused edge. The outcome is read back afterwards.

// File: rtl/kg_pkg.sv
package kg_pkg;
  typedef enum logic [1:0] {
    AK_NONE = 2'd0,
    AK_CFG  = 2'd1,
    AK_LOCK = 2'd2,
    AK_KICK = 2'd3
  } acc_kind_t;
endpackage

// File: rtl/kg_lock_slot.sv
module kg_lock_slot #(
  parameter int DATA_W = 32,
  parameter int WINDOW = 4,
  parameter logic [DATA_W-1:0] KEY = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              open
);
  localparam int   CNT_W    = $clog2(WINDOW + 1);
  localparam logic KEY_USED = (KEY != '0);

  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] next_count(input logic wr,
                                                  input logic [DATA_W-1:0] d,
                                                  input logic [CNT_W-1:0] cur);
    if (wr) return (KEY_USED && d == KEY) ? CNT_W'(WINDOW) : '0;
    if (cur != '0) return cur - 1'b1;
    return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= next_count(lk_wr, wdata, count_q);
  end

  assign open = (count_q != '0);

  // R3
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_wr && KEY_USED && wdata == KEY) |=> open);
  // R5
  zero_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_wr && wdata == '0) |=> !open);
  // R6
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_wr && wdata != KEY) |=> !open);
  // R4
  window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_wr && count_q == CNT_W'(1)) |=> !open);
endmodule

// File: rtl/kg_kick_pair.sv
module kg_kick_pair #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY0 = '1,
  parameter logic [DATA_W-1:0] KEY1 = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr0,
  input  logic              wr1,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] val0,
  output logic [DATA_W-1:0] val1,
  output logic              open
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val0 <= '0;
      val1 <= '0;
    end else begin
      if (wr0) val0 <= wdata;
      if (wr1) val1 <= wdata;
    end
  end

  assign open = (val0 == KEY0) && (val1 == KEY1);

  // R9
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr0 || wr1) && wdata == '0) |=> !open);
  // R8
  kick_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1 && !wr0 && wdata == KEY1 && val0 == KEY0) |=> open);
endmodule

// File: rtl/kg_cfg_bank.sv
module kg_cfg_bank #(
  parameter int DATA_W = 32,
  parameter int N_CFG  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CFG-1:0]        wr_sel,
  input  logic [N_CFG-1:0]        allow,
  input  logic [DATA_W-1:0]       wdata,
  output logic [N_CFG*DATA_W-1:0] q,
  output logic                    accept,
  output logic                    drop
);
  assign accept = |(wr_sel & allow);
  assign drop   = |(wr_sel & ~allow);

  for (genvar i = 0; i < N_CFG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     q[i*DATA_W +: DATA_W] <= '0;
      else if (wr_sel[i] && allow[i]) q[i*DATA_W +: DATA_W] <= wdata;
    end

    // R3
    store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[i] && allow[i]) |=> (q[i*DATA_W +: DATA_W] == $past(wdata)));
  end

  // R7
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !accept) |=> $stable(q));
  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
endmodule

// File: rtl/key_guarded_regs.sv
module key_guarded_regs
  import kg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int N_CFG     = 8,
  parameter int N_LOCK    = 4,
  parameter int WINDOW    = 4,
  parameter int LOCK_BASE = 16,
  parameter int KICK_BASE = 24,
  parameter logic [N_LOCK*8-1:0]      LOCK_REGS = {8'd4, 8'd3, 8'd2, 8'd1},
  parameter logic [N_LOCK*DATA_W-1:0] LOCK_KEYS = {32'hC3C3_0004, 32'h0000_0000,
                                                   32'h5A5A_0002, 32'hA5A5_0001},
  parameter logic [N_CFG-1:0]         KICK_MASK = 8'hE2,
  parameter logic [DATA_W-1:0]        KICK_KEY0 = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0]        KICK_KEY1 = 32'h95A4_F1E0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_we,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic [N_CFG*DATA_W-1:0] cfg_out
);
  logic [N_CFG-1:0]  cfg_hit, wr_sel, allow;
  logic [N_LOCK-1:0] lock_hit, lock_wr, lock_open;
  logic              kick_hit0, kick_hit1, kick_open;
  logic [DATA_W-1:0] kick_val0, kick_val1;
  logic              accept_evt, drop_evt;
  acc_kind_t         kind;

  // A register with a used slot obeys only that slot; otherwise the kick mask decides.
  function automatic logic reg_allowed(input int i, input logic [N_LOCK-1:0] opn,
                                       input logic kopen);
    logic guarded;
    logic unlocked;
    guarded  = 1'b0;
    unlocked = 1'b0;
    for (int j = 0; j < N_LOCK; j++) begin
      if (LOCK_KEYS[j*DATA_W +: DATA_W] != '0 && int'(LOCK_REGS[j*8 +: 8]) == i) begin
        guarded  = 1'b1;
        unlocked = unlocked | opn[j];
      end
    end
    if (guarded)      return unlocked;
    if (KICK_MASK[i]) return kopen;
    return 1'b1;
  endfunction

  always_comb begin
    for (int i = 0; i < N_CFG; i++) begin
      cfg_hit[i] = (bus_addr == ADDR_W'(i));
      allow[i]   = reg_allowed(i, lock_open, kick_open);
    end
    for (int j = 0; j < N_LOCK; j++) lock_hit[j] = (bus_addr == ADDR_W'(LOCK_BASE + j));
    kick_hit0 = (bus_addr == ADDR_W'(KICK_BASE));
    kick_hit1 = (bus_addr == ADDR_W'(KICK_BASE + 1));
  end

  assign wr_sel  = cfg_hit & {N_CFG{bus_we}};
  assign lock_wr = lock_hit & {N_LOCK{bus_we}};

  for (genvar j = 0; j < N_LOCK; j++) begin : g_slot
    kg_lock_slot #(
      .DATA_W(DATA_W), .WINDOW(WINDOW), .KEY(LOCK_KEYS[j*DATA_W +: DATA_W])
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .lk_wr(lock_wr[j]), .wdata(bus_wdata),
      .open(lock_open[j])
    );
  end

  kg_kick_pair #(.DATA_W(DATA_W), .KEY0(KICK_KEY0), .KEY1(KICK_KEY1)) u_kick (
    .clk(clk), .rst_n(rst_n), .wr0(bus_we && kick_hit0), .wr1(bus_we && kick_hit1),
    .wdata(bus_wdata), .val0(kick_val0), .val1(kick_val1), .open(kick_open)
  );

  kg_cfg_bank #(.DATA_W(DATA_W), .N_CFG(N_CFG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .allow(allow), .wdata(bus_wdata),
    .q(cfg_out), .accept(accept_evt), .drop(drop_evt)
  );

  always_comb begin
    kind = AK_NONE;
    if (|cfg_hit)                    kind = AK_CFG;
    else if (|lock_hit)              kind = AK_LOCK;
    else if (kick_hit0 || kick_hit1) kind = AK_KICK;
  end

  always_comb begin
    bus_rdata = '0;
    case (kind)
      AK_CFG:
        for (int i = 0; i < N_CFG; i++)
          if (cfg_hit[i]) bus_rdata = cfg_out[i*DATA_W +: DATA_W];
      AK_LOCK:
        for (int j = 0; j < N_LOCK; j++)
          if (lock_hit[j]) bus_rdata = {{(DATA_W-1){1'b0}}, lock_open[j]};
      AK_KICK: bus_rdata = kick_hit0 ? kick_val0 : kick_val1;
      default: bus_rdata = '0;
    endcase
  end

  // R10
  lock_over_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[LOCK_REGS[7:0]] && !lock_open[0] && LOCK_KEYS[DATA_W-1:0] != '0)
      |=> $stable(cfg_out[LOCK_REGS[7:0]*DATA_W +: DATA_W]));
  // R7
  drop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> $stable(cfg_out));
endmodule

// File: tb/test_key_guarded_regs.sv
module test_key_guarded_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [255:0] cfg_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  localparam logic [31:0] K0 = 32'hA5A5_0001, K1 = 32'h5A5A_0002, K3 = 32'hC3C3_0004;
  localparam logic [31:0] KA = 32'h83E7_0B13, KB = 32'h95A4_F1E0;

  always #5 clk = ~clk;

  key_guarded_regs i_key_guarded_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .cfg_out(cfg_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) rd_chk("R1 cfg", 5'(i), 32'h0);
    for (int j = 16; j < 20; j++) rd_chk("R1 lock", 5'(j), 32'h0);
    rd_chk("R1 kick0", 5'd24, 32'h0);
    rd_chk("R1 kick1", 5'd25, 32'h0);
  endtask

  task automatic t_free;
    wr(5'd0, 32'h1111_0000);
    rd_chk("R2 reg0", 5'd0, 32'h1111_0000);
    wr(5'd18, 32'hDEAD_BEEF);
    rd_chk("R11 unused lock reads 0", 5'd18, 32'h0);
    wr(5'd3, 32'h3333_0003);
    rd_chk("R11 reg3 unguarded", 5'd3, 32'h3333_0003);
    chk("R2 cfg_out reg3", cfg_out[3*32 +: 32], 32'h3333_0003);
    rd_chk("R12 unmapped", 5'd30, 32'h0);
  endtask

  task automatic t_window;
    wr(5'd16, K0);
    wr(5'd1, 32'h0101_0001);
    rd_chk("R3 first window cycle", 5'd1, 32'h0101_0001);
    wr(5'd16, K0);
    idle(3);
    wr(5'd1, 32'h0101_0004);
    rd_chk("R3 last window cycle", 5'd1, 32'h0101_0004);
    wr(5'd16, K0);
    idle(4);
    wr(5'd1, 32'h0101_0005);
    rd_chk("R4 R7 past window", 5'd1, 32'h0101_0004);
    wr(5'd2, 32'h0202_0000);
    rd_chk("R7 locked reg2 read", 5'd2, 32'h0);
  endtask

  task automatic t_status;
    wr(5'd17, K1);
    rd_chk("R12 lock open bit", 5'd17, 32'h1);
    idle(5);
    rd_chk("R12 lock closed after window", 5'd17, 32'h0);
  endtask

  task automatic t_zero;
    wr(5'd19, K3);
    wr(5'd19, 32'h0);
    wr(5'd4, 32'h0404_0004);
    rd_chk("R5 zero relock", 5'd4, 32'h0);
  endtask

  task automatic t_badkey;
    wr(5'd17, K1);
    wr(5'd17, 32'h1234_5678);
    rd_chk("R6 wrong key status", 5'd17, 32'h0);
    wr(5'd2, 32'h0202_0002);
    rd_chk("R6 wrong key cancels", 5'd2, 32'h0);
  endtask

  task automatic t_kick;
    wr(5'd5, 32'h0505_0001);
    rd_chk("R8 no kick", 5'd5, 32'h0);
    wr(5'd24, KA);
    wr(5'd6, 32'h0606_0001);
    rd_chk("R8 one kick only", 5'd6, 32'h0);
    wr(5'd25, KB);
    wr(5'd6, 32'h0606_0002);
    rd_chk("R8 both kicks", 5'd6, 32'h0606_0002);
    rd_chk("R12 kick0 readback", 5'd24, KA);
    rd_chk("R12 kick1 readback", 5'd25, KB);
    wr(5'd1, 32'h0101_0009);
    rd_chk("R10 kick ignored for locked reg", 5'd1, 32'h0101_0004);
    wr(5'd24, 32'h0);
    wr(5'd25, 32'h0);
    wr(5'd7, 32'h0707_0007);
    rd_chk("R9 cleared kicks", 5'd7, 32'h0);
    wr(5'd16, K0);
    wr(5'd1, 32'h0101_000A);
    rd_chk("R10 lock alone suffices", 5'd1, 32'h0101_000A);
    wr(5'd24, KA);
    wr(5'd25, 32'h0000_0001);
    wr(5'd5, 32'h0505_0002);
    rd_chk("R8 wrong second key", 5'd5, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_free();
    t_window();
    t_status();
    t_zero();
    t_badkey();
    t_kick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule